// File: doc/BRIEF.md
# Ethernet Audio Frame Filter

This block sits between an Ethernet receive MAC and an audio playback path. The MAC hands over raw frames as a stream of 32-bit words on a 25 MHz clock, each word qualified by a valid strobe. The frame ends with a one-cycle marker that reports whether the CRC was good or bad. The block checks the first four words of every frame against a fixed destination address, source address and frame type. It forwards only the PCM sample words of frames whose header matches. Every word of any other frame is discarded until that frame's end marker.

The playback side runs on its own 12.288 MHz clock. Accepted samples cross into that domain through a 16-entry dual-clock FIFO whose pointers are Gray coded and pass through two-flop synchronizers. The consumer raises a request, and the block answers on the next audio clock edge with a registered sample and a one-cycle valid flag, provided a sample is waiting. The header check runs one word at a time as data arrives, so nothing is buffered on the Ethernet side. A word counter and a header-ok flag return to their initial state at every end marker, so a truncated or corrupt frame cannot disturb the frame that follows it.

Top module: `eth_audio_filter`

## Requirements
- R1: A frame is forwarded only when its header words carry the expected fields. Word index 0 must equal 0xFFFFFFFF. Word index 1 must equal 0xFFFF0090. Word index 2 must equal 0xC2001C50. Bits 31:16 of word index 3 must equal 0x0101. The words at index 4 through 1027 of such a frame then appear on `out_data`, in arrival order and unchanged.
- R2: If word index 0 (the top of the destination address) differs from its expected value, no word of that frame is forwarded.
- R3: If either word that carries source address bits differs from its expected value, no word of that frame is forwarded. These are word index 1, bits 15:0, and word index 2.
- R4: If bits 31:16 of word index 3 (the frame type) differ from 0x0101, no word of that frame is forwarded.
- R5: Bits 15:0 of word index 3 are padding and have no effect on whether the frame is forwarded.
- R6: Either end marker (`in_end_good` or `in_end_bad`) restarts the word count at zero and re-arms the header check. A short frame, or one that failed its header check, therefore has no effect on the next frame.
- R7: In a frame longer than 1028 words, no word after index 1027 is forwarded.
- R8: When the FIFO already holds 16 samples, an arriving sample is dropped and the MAC is never stalled. The samples already stored are delivered intact.
- R9: A request made while no sample is waiting leaves `out_valid` low and consumes nothing, so a later sample is still delivered in order.
- R10: While `aud_rst` is high, and after it is released while no sample is waiting, `out_valid` stays low.
- R11: `out_valid` rises for exactly one audio cycle, and only in the cycle after a request. The word counter advances once per valid input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eth_clk | input | 1 | Ethernet-side clock (25 MHz) |
| eth_rst | input | 1 | Synchronous active-high reset, Ethernet domain |
| in_data | input | 32 | Frame word from the MAC |
| in_valid | input | 1 | `in_data` holds a frame word this cycle |
| in_end_good | input | 1 | One-cycle end-of-frame marker, CRC good |
| in_end_bad | input | 1 | One-cycle end-of-frame marker, CRC bad |
| aud_clk | input | 1 | Audio-side clock (12.288 MHz) |
| aud_rst | input | 1 | Synchronous active-high reset, audio domain |
| out_request | input | 1 | Consumer asks for the next sample |
| out_data | output | 32 | Registered sample word |
| out_valid | output | 1 | `out_data` carries a sample this cycle |

## Verification
The bench sends frames with a fault in each header field in turn, plus one frame whose padding alone differs. A design that compared the wrong word, or that compared the padding, would leak dropped frames or lose good ones. A two-word runt frame and a frame whose header failed at word 0 are each followed at once by a good frame. A counter or flag that did not restart on the end marker would shift the next frame's header window and drop the whole frame. An overlong frame of 1100 words shows whether the upper bound on the forwarding window holds; a bound that wrapped or was missing would emit extra samples. A frame sent while the consumer is idle fills the FIFO. Requests made into an empty FIFO check that the full flag and the empty flag never overwrite stored data or invent a sample.

// File: rtl/eaf_pkg.sv
`timescale 1ns/1ps
package eaf_pkg;

  localparam int DATA_W    = 32;
  localparam int HDR_WORDS = 4;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic [DATA_W-1:0] mask;
  } hdr_pat_t;

  // Expected content of header word idx and the bits that take part in the compare.
  function automatic hdr_pat_t hdr_pattern(input logic [1:0]  idx,
                                           input logic [47:0] dst,
                                           input logic [47:0] src,
                                           input logic [15:0] ftype);
    hdr_pat_t p;
    case (idx)
      2'd0:    begin p.value = dst[47:16];               p.mask = '1;            end
      2'd1:    begin p.value = {dst[15:0], src[47:32]};  p.mask = '1;            end
      2'd2:    begin p.value = src[31:0];                p.mask = '1;            end
      default: begin p.value = {ftype, 16'h0000};        p.mask = 32'hFFFF_0000; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/eaf_header_filter.sv
`timescale 1ns/1ps
module eaf_header_filter
  import eaf_pkg::*;
#(
  parameter int          PAYLOAD_WORDS = 1024,
  parameter int          CNT_W         = 11,
  parameter logic [47:0] DST_ADDR      = 48'hFFFF_FFFF_FFFF,
  parameter logic [47:0] SRC_ADDR      = 48'h0090_C200_1C50,
  parameter logic [15:0] FRAME_TYPE    = 16'h0101
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              end_good,
  input  logic              end_bad,
  output logic              pay_wr,
  output logic [DATA_W-1:0] pay_data,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              hdr_ok
);

  localparam int             LAST_IDX = HDR_WORDS + PAYLOAD_WORDS - 1;
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_WORDS);
  localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(LAST_IDX);

  logic     frame_end;
  logic     in_hdr;
  logic     in_pay;
  logic     hdr_hit;
  hdr_pat_t pat;

  assign frame_end = end_good | end_bad;
  assign in_hdr    = (word_cnt < HDR_END);
  assign in_pay    = (word_cnt >= HDR_END) && (word_cnt <= PAY_LAST);
  assign pat       = hdr_pattern(word_cnt[1:0], DST_ADDR, SRC_ADDR, FRAME_TYPE);
  assign hdr_hit   = ((in_data ^ pat.value) & pat.mask) == '0;

  assign pay_wr    = in_valid && hdr_ok && in_pay;
  assign pay_data  = in_data;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      word_cnt <= '0;
      hdr_ok   <= 1'b1;
    end else if (in_valid) begin
      if (word_cnt != CNT_SAT)
        word_cnt <= word_cnt + 1'b1;
      if (in_hdr && !hdr_hit)
        hdr_ok <= 1'b0;
    end
  end

endmodule

// File: rtl/eaf_sync2.sv
`timescale 1ns/1ps
module eaf_sync2 #(
  parameter int W = 5
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/eaf_async_fifo.sv
`timescale 1ns/1ps
module eaf_async_fifo #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
)(
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_empty
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, wbin_nxt;
  logic [AW:0] rbin, rgray, rbin_nxt;
  logic [AW:0] rgray_w, wgray_r;
  logic        wr_acc, rd_acc;

  // ---------------- write side ----------------
  assign wbin_nxt = wbin + 1'b1;
  assign wr_full  = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign wr_acc   = wr_req && !wr_full;

  always_ff @(posedge wclk) begin
    if (wr_acc)
      mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_acc) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  eaf_sync2 #(.W(AW + 1)) u_rptr_sync (
    .clk (wclk),
    .rst (wrst),
    .d   (rgray),
    .q   (rgray_w)
  );

  // ---------------- read side ----------------
  assign rbin_nxt = rbin + 1'b1;
  assign rd_empty = (rgray == wgray_r);
  assign rd_acc   = rd_req && !rd_empty;

  always_ff @(posedge rclk) begin
    if (rd_acc)
      rd_data <= mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
  end

  eaf_sync2 #(.W(AW + 1)) u_wptr_sync (
    .clk (rclk),
    .rst (rrst),
    .d   (wgray),
    .q   (wgray_r)
  );

endmodule

// File: rtl/eth_audio_filter.sv
`timescale 1ns/1ps
module eth_audio_filter
  import eaf_pkg::*;
#(
  parameter int          PAYLOAD_WORDS = 1024,
  parameter int          CNT_W         = 11,
  parameter int          FIFO_AW       = 4,
  parameter logic [47:0] DST_ADDR      = 48'hFFFF_FFFF_FFFF,
  parameter logic [47:0] SRC_ADDR      = 48'h0090_C200_1C50,
  parameter logic [15:0] FRAME_TYPE    = 16'h0101
)(
  input  logic        eth_clk,
  input  logic        eth_rst,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  input  logic        in_end_good,
  input  logic        in_end_bad,
  input  logic        aud_clk,
  input  logic        aud_rst,
  input  logic        out_request,
  output logic [31:0] out_data,
  output logic        out_valid
);

  logic              pay_wr;
  logic [DATA_W-1:0] pay_data;
  logic [CNT_W-1:0]  word_cnt;
  logic              hdr_ok;
  logic              fifo_full;
  logic              fifo_empty;

  eaf_header_filter #(
    .PAYLOAD_WORDS (PAYLOAD_WORDS),
    .CNT_W         (CNT_W),
    .DST_ADDR      (DST_ADDR),
    .SRC_ADDR      (SRC_ADDR),
    .FRAME_TYPE    (FRAME_TYPE)
  ) u_filter (
    .clk      (eth_clk),
    .rst      (eth_rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .end_good (in_end_good),
    .end_bad  (in_end_bad),
    .pay_wr   (pay_wr),
    .pay_data (pay_data),
    .word_cnt (word_cnt),
    .hdr_ok   (hdr_ok)
  );

  eaf_async_fifo #(
    .DATA_W (DATA_W),
    .AW     (FIFO_AW)
  ) u_fifo (
    .wclk     (eth_clk),
    .wrst     (eth_rst),
    .wr_req   (pay_wr),
    .wr_data  (pay_data),
    .wr_full  (fifo_full),
    .rclk     (aud_clk),
    .rrst     (aud_rst),
    .rd_req   (out_request),
    .rd_data  (out_data),
    .rd_valid (out_valid),
    .rd_empty (fifo_empty)
  );

endmodule

// File: rtl/eaf_checker.sv
`timescale 1ns/1ps
module eaf_checker #(
  parameter int CNT_W = 11
)(
  input logic             eth_clk,
  input logic             eth_rst,
  input logic             in_valid,
  input logic             in_end_good,
  input logic             in_end_bad,
  input logic [CNT_W-1:0] word_cnt,
  input logic             hdr_ok,
  input logic             aud_clk,
  input logic             aud_rst,
  input logic             out_request,
  input logic             out_valid,
  input logic             fifo_empty
);

  logic frame_end;
  assign frame_end = in_end_good | in_end_bad;

  // R6: an end marker restarts the count and re-arms the header check
  a_r6_marker_restarts: assert property (@(posedge eth_clk) disable iff (eth_rst)
    frame_end |=> (word_cnt == '0) && hdr_ok);

  // R11: counter advances once per valid word until saturation
  a_r11_count_steps: assert property (@(posedge eth_clk) disable iff (eth_rst)
    (in_valid && !frame_end && (word_cnt != '1)) |=> (word_cnt == $past(word_cnt) + 1'b1));

  // R2: a failed header check persists until the frame ends
  a_r2_mismatch_sticks: assert property (@(posedge eth_clk) disable iff (eth_rst)
    (!hdr_ok && !frame_end) |=> !hdr_ok);

  // R9: a request into an empty FIFO yields no valid sample
  a_r9_empty_no_valid: assert property (@(posedge aud_clk) disable iff (aud_rst)
    (out_request && fifo_empty) |=> !out_valid);

  // R11: every valid sample answers a request in the previous cycle
  a_r11_valid_after_request: assert property (@(posedge aud_clk) disable iff (aud_rst)
    out_valid |-> $past(out_request));

endmodule

bind eth_audio_filter eaf_checker #(.CNT_W(CNT_W)) u_checker (
  .eth_clk     (eth_clk),
  .eth_rst     (eth_rst),
  .in_valid    (in_valid),
  .in_end_good (in_end_good),
  .in_end_bad  (in_end_bad),
  .word_cnt    (word_cnt),
  .hdr_ok      (hdr_ok),
  .aud_clk     (aud_clk),
  .aud_rst     (aud_rst),
  .out_request (out_request),
  .out_valid   (out_valid),
  .fifo_empty  (fifo_empty)
);

// File: tb/eth_audio_filter_bench.sv
`timescale 1ns/1ps
module eth_audio_filter_bench;

  localparam int ETH_PERIOD = 40;
  localparam int AUD_PERIOD = 82;
  localparam int WORD_GAP   = 4;
  localparam logic [31:0] H0 = 32'hFFFF_FFFF;
  localparam logic [31:0] H1 = 32'hFFFF_0090;
  localparam logic [31:0] H2 = 32'hC200_1C50;
  localparam logic [31:0] H3 = 32'h0101_1234;

  logic        eth_clk = 1'b0;
  logic        aud_clk = 1'b0;
  logic        eth_rst = 1'b1;
  logic        aud_rst = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_end_good = 1'b0;
  logic        in_end_bad = 1'b0;
  logic        out_request = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;

  logic        req_en = 1'b0;
  int          checks = 0;
  int          errors = 0;
  int          seen   = 0;
  string       cur_tag = "R10";
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(ETH_PERIOD/2) eth_clk = ~eth_clk;
  always #(AUD_PERIOD/2) aud_clk = ~aud_clk;

  eth_audio_filter u_eth_audio_filter (
    .eth_clk     (eth_clk),
    .eth_rst     (eth_rst),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_end_good (in_end_good),
    .in_end_bad  (in_end_bad),
    .aud_clk     (aud_clk),
    .aud_rst     (aud_rst),
    .out_request (out_request),
    .out_data    (out_data),
    .out_valid   (out_valid)
  );

  always @(negedge aud_clk) out_request <= req_en;

  // Monitor: pops the scoreboard on every delivered sample.
  always @(negedge aud_clk) begin
    if (!aud_rst && out_valid) begin
      logic [31:0] e;
      string       t;
      seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected sample actual=%h expected=none", cur_tag, out_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_data !== e) begin
          errors++;
          $display("FAIL %s: sample actual=%h expected=%h", t, out_data, e);
        end
      end
    end
  end

  task automatic send_word(input logic [31:0] d);
    @(negedge eth_clk);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge eth_clk);
    in_valid = 1'b0;
    repeat (WORD_GAP - 2) @(negedge eth_clk);
  endtask

  // Driver: computes expected samples from the header rules and pushes them.
  task automatic send_frame(input logic [7:0] fid, input int nwords,
                            input logic [31:0] h0, input logic [31:0] h1,
                            input logic [31:0] h2, input logic [31:0] h3,
                            input bit good_end, input int limit,
                            input string tag, output int nexp);
    bit hit;
    logic [31:0] d;
    cur_tag = tag;
    nexp = 0;
    hit = (h0 == 32'hFFFF_FFFF) && (h1 == 32'hFFFF_0090) &&
          (h2 == 32'hC200_1C50) && (h3[31:16] == 16'h0101);
    for (int i = 0; i < nwords; i++) begin
      case (i)
        0: d = h0;
        1: d = h1;
        2: d = h2;
        3: d = h3;
        default: d = {fid, 8'hA5, 16'(i)};
      endcase
      if (hit && i >= 4 && i <= 1027 && nexp < limit) begin
        exp_q.push_back(d);
        tag_q.push_back(tag);
        nexp++;
      end
      send_word(d);
    end
    @(negedge eth_clk);
    if (good_end) in_end_good = 1'b1; else in_end_bad = 1'b1;
    @(negedge eth_clk);
    in_end_good = 1'b0;
    in_end_bad  = 1'b0;
    repeat (4) @(negedge eth_clk);
  endtask

  task automatic frame_done(input string tag, input int nexp, input int seen0);
    repeat (200) @(negedge aud_clk);
    checks++;
    if ((seen - seen0) != nexp || exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: samples delivered actual=%0d expected=%0d (pending %0d)",
               tag, seen - seen0, nexp, exp_q.size());
    end
  endtask

  initial begin
    repeat (150000) @(posedge eth_clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int s0;
    req_en = 1'b1;
    repeat (10) @(negedge aud_clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: out_valid in reset actual=%b expected=0", out_valid);
    end
    @(negedge eth_clk); eth_rst = 1'b0;
    @(negedge aud_clk); aud_rst = 1'b0;
    repeat (10) @(negedge aud_clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: out_valid after reset actual=%b expected=0", out_valid);
    end

    s0 = seen; send_frame(8'h01, 1028, H0, H1, H2, H3, 1, 99999, "R1", n);
    frame_done("R1", n, s0);
    s0 = seen; send_frame(8'h02, 1028, 32'hFFFF_FFFE, H1, H2, H3, 1, 99999, "R2", n);
    frame_done("R2", n, s0);
    s0 = seen; send_frame(8'h03, 1028, H0, 32'hFFFF_0091, H2, H3, 1, 99999, "R3", n);
    frame_done("R3", n, s0);
    s0 = seen; send_frame(8'h04, 1028, H0, H1, 32'hC200_1C51, H3, 1, 99999, "R3", n);
    frame_done("R3", n, s0);
    s0 = seen; send_frame(8'h05, 1028, H0, H1, H2, 32'h0102_1234, 1, 99999, "R4", n);
    frame_done("R4", n, s0);
    s0 = seen; send_frame(8'h06, 1028, H0, H1, H2, 32'h0101_BEEF, 1, 99999, "R5", n);
    frame_done("R5", n, s0);

    // R6: runt frame, then a good frame right behind it
    s0 = seen; send_frame(8'h07, 2, H0, H1, H2, H3, 0, 99999, "R6", n);
    frame_done("R6", n, s0);
    s0 = seen; send_frame(8'h08, 1028, H0, H1, H2, H3, 1, 99999, "R6", n);
    frame_done("R6", n, s0);
    // R6: header failure at word 0, then a good frame
    s0 = seen; send_frame(8'h09, 3, 32'h0, H1, H2, H3, 0, 99999, "R6", n);
    frame_done("R6", n, s0);
    s0 = seen; send_frame(8'h0A, 1028, H0, H1, H2, H3, 1, 99999, "R6", n);
    frame_done("R6", n, s0);

    // R9: requests into an empty FIFO
    cur_tag = "R9";
    for (int k = 0; k < 40; k++) begin
      @(negedge aud_clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R9: out_valid while empty actual=%b expected=0", out_valid);
      end
    end
    s0 = seen; send_frame(8'h0B, 1028, H0, H1, H2, H3, 1, 99999, "R9", n);
    frame_done("R9", n, s0);

    // R7: overlong frame
    s0 = seen; send_frame(8'h0C, 1100, H0, H1, H2, H3, 1, 99999, "R7", n);
    frame_done("R7", n, s0);

    // R8: consumer idle, FIFO fills after 16 samples
    req_en = 1'b0;
    repeat (4) @(negedge aud_clk);
    s0 = seen; send_frame(8'h0D, 1028, H0, H1, H2, H3, 1, 16, "R8", n);
    repeat (20) @(negedge aud_clk);
    req_en = 1'b1;
    frame_done("R8", n, s0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule